// File: doc/BRIEF.md
# Horizontal Microcoded Control Sequencer

This block is the control unit of a multicycle processor, built as a small microprogrammed engine. A micro-program counter (uPC) addresses a constant microcode store. Each stored word carries 18 horizontal control bits and a 2-bit sequencing code. The control bits leave the block with no decoding, so each microword is one state of the equivalent state machine and each clock cycle runs exactly one microword.

The sequencing code picks the next uPC. It can step to uPC+1, return to the fetch word at address 0, or make an indirect jump through one of two opcode-indexed dispatch tables. The opcode input is sampled only when a dispatch is taken. The microword states are: FETCH (0), DECODE (1), MADDR (2, memory address compute), LDRD (3, load memory read), LDWB (4, load register write-back), STWR (5, store write), REXE (6, register-type execute), RWB (7, register-type write-back), BR (8, branch compare), JMP (9, jump). Addresses 10 to 15 hold all-zero control bits and return to fetch.

The transitions are:
- FETCH→DECODE: step.
- DECODE→{MADDR, REXE, BR, JMP, FETCH}: dispatch through table 1.
- MADDR→{LDRD, STWR, FETCH}: dispatch through table 2.
- LDRD→LDWB and REXE→RWB: step.
- LDWB, STWR, RWB, BR and JMP: return to FETCH.

Top module: `usq_sequencer`

## Requirements
- R1: An active-high asynchronous reset `rst` forces the uPC to 0. While the uPC is 0, `ctl` shows the fetch word.
- R2: The uPC changes only on the rising clock edge. One microword runs per cycle.
- R3: `ctl` equals the control bits of the word at the uPC, with no decoding. The field positions are:
  - ALU op [17:16]
  - A-source [15]
  - B-source [14:13]
  - register file {write, dest-select, mem-to-reg} [12:10]
  - memory {read, write, address-select, IR write} [9:6]
  - PC {write, conditional write, source[1:0]} [5:2]
  - latches {ALU-out, data} [1:0]

  The fetch word is 18'b00_0_01_000_1001_1000_00. It asserts IR write together with memory read.
- R4: Sequencing code 2'b11 makes the next uPC equal to uPC+1.
- R5: Sequencing code 2'b00 makes the next uPC equal to 0.
- R6: Sequencing code 2'b01 makes the next uPC the table-1 entry for the opcode. The entries are: 6'h00→6, 6'h02→9, 6'h04→8, 6'h23→2 and 6'h2B→2.
- R7: Sequencing code 2'b10 makes the next uPC the table-2 entry for the opcode. The entries are: 6'h23→3 and 6'h2B→5.
- R8: An opcode with no entry in the selected table makes the next uPC 0.
- R9: The uPC traces for each instruction class are:
  - 6'h23: 0,1,2,3,4
  - 6'h2B: 0,1,2,5
  - 6'h00: 0,1,6,7
  - 6'h04: 0,1,8
  - 6'h02: 0,1,9

  Every trace then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| opcode | input | 6 | Instruction opcode used by dispatch |
| ctl | output | 18 | Horizontal control lines of the current microword |
| upc | output | 4 | Current micro-address |

## Verification
The assertions check three rules on every cycle: a step code advances the uPC by one, a return code lands on address 0, and IR write never appears without memory read. They also check two dispatch targets that follow from the opcode seen in the preceding cycle. Only the bench scenarios show the following:
- each instruction class runs its full uPC trace, and every control vector along it is correct;
- unmapped opcodes fall back to fetch;
- a reset in the middle of a routine restarts at the fetch word.

// File: rtl/usq_pkg.sv
package usq_pkg;
    localparam int OP_W   = 6;
    localparam int UA_W   = 4;
    localparam int CTL_W  = 18;
    localparam int N_TBL  = 2;

    typedef enum logic [1:0] {
        SQ_FETCH = 2'b00,
        SQ_TBL1  = 2'b01,
        SQ_TBL2  = 2'b10,
        SQ_STEP  = 2'b11
    } sq_e;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        sq_e              sq;
    } uword_t;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OPC_JMP   = 6'h02;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

    localparam logic [UA_W-1:0] UA_FETCH  = 4'd0;
    localparam logic [UA_W-1:0] UA_DECODE = 4'd1;
    localparam logic [UA_W-1:0] UA_MADDR  = 4'd2;
    localparam logic [UA_W-1:0] UA_LDRD   = 4'd3;
    localparam logic [UA_W-1:0] UA_LDWB   = 4'd4;
    localparam logic [UA_W-1:0] UA_STWR   = 4'd5;
    localparam logic [UA_W-1:0] UA_REXE   = 4'd6;
    localparam logic [UA_W-1:0] UA_RWB    = 4'd7;
    localparam logic [UA_W-1:0] UA_BR     = 4'd8;
    localparam logic [UA_W-1:0] UA_JMP    = 4'd9;
endpackage

// File: rtl/usq_store.sv
module usq_store
    import usq_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uword_t          word
);
    // fields: {alu[2], srca[1], srcb[2], rf[3], mem[4], pc[4], lat[2]}
    always_comb begin
        case (addr)
            UA_FETCH:  word = '{ctl: {2'b00, 1'b0, 2'b01, 3'b000, 4'b1001, 4'b1000, 2'b00}, sq: SQ_STEP};
            UA_DECODE: word = '{ctl: {2'b00, 1'b0, 2'b11, 3'b000, 4'b0000, 4'b0000, 2'b10}, sq: SQ_TBL1};
            UA_MADDR:  word = '{ctl: {2'b00, 1'b1, 2'b10, 3'b000, 4'b0000, 4'b0000, 2'b10}, sq: SQ_TBL2};
            UA_LDRD:   word = '{ctl: {2'b00, 1'b0, 2'b00, 3'b000, 4'b1010, 4'b0000, 2'b01}, sq: SQ_STEP};
            UA_LDWB:   word = '{ctl: {2'b00, 1'b0, 2'b00, 3'b101, 4'b0000, 4'b0000, 2'b00}, sq: SQ_FETCH};
            UA_STWR:   word = '{ctl: {2'b00, 1'b0, 2'b00, 3'b000, 4'b0110, 4'b0000, 2'b00}, sq: SQ_FETCH};
            UA_REXE:   word = '{ctl: {2'b10, 1'b1, 2'b00, 3'b000, 4'b0000, 4'b0000, 2'b10}, sq: SQ_STEP};
            UA_RWB:    word = '{ctl: {2'b00, 1'b0, 2'b00, 3'b110, 4'b0000, 4'b0000, 2'b00}, sq: SQ_FETCH};
            UA_BR:     word = '{ctl: {2'b01, 1'b1, 2'b00, 3'b000, 4'b0000, 4'b0101, 2'b00}, sq: SQ_FETCH};
            UA_JMP:    word = '{ctl: {2'b00, 1'b0, 2'b00, 3'b000, 4'b0000, 4'b1010, 2'b00}, sq: SQ_FETCH};
            default:   word = '{ctl: '0, sq: SQ_FETCH};
        endcase
    end
endmodule

// File: rtl/usq_dispatch.sv
module usq_dispatch
    import usq_pkg::*;
#(
    parameter int TBL_ID = 0
) (
    input  logic [OP_W-1:0] op,
    output logic [UA_W-1:0] target
);
    generate
        if (TBL_ID == 0) begin : g_decode_tbl
            always_comb begin
                case (op)
                    OPC_RTYPE: target = UA_REXE;
                    OPC_JMP:   target = UA_JMP;
                    OPC_BEQ:   target = UA_BR;
                    OPC_LOAD:  target = UA_MADDR;
                    OPC_STORE: target = UA_MADDR;
                    default:   target = UA_FETCH;
                endcase
            end
        end else begin : g_mem_tbl
            always_comb begin
                case (op)
                    OPC_LOAD:  target = UA_LDRD;
                    OPC_STORE: target = UA_STWR;
                    default:   target = UA_FETCH;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/usq_next.sv
module usq_next
    import usq_pkg::*;
(
    input  sq_e                        sq,
    input  logic [UA_W-1:0]            cur,
    input  logic [N_TBL-1:0][UA_W-1:0] tbl,
    output logic [UA_W-1:0]            nxt
);
    always_comb begin
        unique case (sq)
            SQ_FETCH: nxt = UA_FETCH;
            SQ_TBL1:  nxt = tbl[0];
            SQ_TBL2:  nxt = tbl[1];
            SQ_STEP:  nxt = cur + UA_W'(1);
        endcase
    end
endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer
    import usq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode,
    output logic [CTL_W-1:0]  ctl,
    output logic [UA_W-1:0]   upc
);
    uword_t                     cur;
    logic [N_TBL-1:0][UA_W-1:0] tbl_tgt;
    logic [UA_W-1:0]            upc_nxt;

    usq_store u_store (
        .addr (upc),
        .word (cur)
    );

    generate
        for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
            usq_dispatch #(.TBL_ID(t)) u_disp (
                .op     (opcode),
                .target (tbl_tgt[t])
            );
        end
    endgenerate

    usq_next u_next (
        .sq  (cur.sq),
        .cur (upc),
        .tbl (tbl_tgt),
        .nxt (upc_nxt)
    );

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) upc <= UA_FETCH;
        else     upc <= upc_nxt;
    end

    // outputs
    always_comb begin
        ctl = cur.ctl;
    end

    // R4
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (cur.sq == SQ_STEP) |=> (upc == UA_W'($past(upc) + UA_W'(1))));

    // R5
    fetch_return_chk: assert property (@(posedge clk) disable iff (rst)
        (cur.sq == SQ_FETCH) |=> (upc == UA_FETCH));

    // R6
    tbl1_rtype_chk: assert property (@(posedge clk) disable iff (rst)
        (cur.sq == SQ_TBL1 && opcode == OPC_RTYPE) |=> (upc == UA_REXE));

    // R7
    tbl2_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cur.sq == SQ_TBL2 && opcode == OPC_LOAD) |=> (upc == UA_LDRD));

    // R3
    ir_read_chk: assert property (@(posedge clk) disable iff (rst)
        ctl[6] |-> ctl[9]);
endmodule

// File: tb/usq_sequencer_bench.sv
module usq_sequencer_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = 6'h00;
    logic [17:0] ctl;
    logic [3:0]  upc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0]  q_addr[$];
    string       q_tag[$];

    always #(CLK_P/2) clk = ~clk;

    usq_sequencer u_usq_sequencer (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .ctl    (ctl),
        .upc    (upc)
    );

    function automatic logic [17:0] exp_ctl(input logic [3:0] a);
        case (a)
            4'd0: return {2'b00, 1'b0, 2'b01, 3'b000, 4'b1001, 4'b1000, 2'b00};
            4'd1: return {2'b00, 1'b0, 2'b11, 3'b000, 4'b0000, 4'b0000, 2'b10};
            4'd2: return {2'b00, 1'b1, 2'b10, 3'b000, 4'b0000, 4'b0000, 2'b10};
            4'd3: return {2'b00, 1'b0, 2'b00, 3'b000, 4'b1010, 4'b0000, 2'b01};
            4'd4: return {2'b00, 1'b0, 2'b00, 3'b101, 4'b0000, 4'b0000, 2'b00};
            4'd5: return {2'b00, 1'b0, 2'b00, 3'b000, 4'b0110, 4'b0000, 2'b00};
            4'd6: return {2'b10, 1'b1, 2'b00, 3'b000, 4'b0000, 4'b0000, 2'b10};
            4'd7: return {2'b00, 1'b0, 2'b00, 3'b110, 4'b0000, 4'b0000, 2'b00};
            4'd8: return {2'b01, 1'b1, 2'b00, 3'b000, 4'b0000, 4'b0101, 2'b00};
            4'd9: return {2'b00, 1'b0, 2'b00, 3'b000, 4'b0000, 4'b1010, 2'b00};
            default: return 18'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] a_got, input logic [3:0] a_exp,
                         input logic [17:0] c_got, input logic [17:0] c_exp);
        checks++;
        if (a_got !== a_exp || c_got !== c_exp) begin
            errors++;
            $display("FAIL %s: upc=%0d ctl=%b expected upc=%0d ctl=%b",
                     tag, a_got, c_got, a_exp, c_exp);
        end
    endtask

    // monitor: pops expected trace entries, one per cycle
    always @(negedge clk) begin
        if (q_addr.size() > 0) begin
            logic [3:0] ea;
            string      et;
            ea = q_addr.pop_front();
            et = q_tag.pop_front();
            check(et, upc, ea, ctl, exp_ctl(ea));
        end
    end

    // driver: path holds addresses, first at the low nibble
    task automatic run_instr(input logic [5:0] op, input int n,
                             input logic [19:0] path, input string tag);
        opcode = op;
        for (int i = 0; i < n; i++) begin
            q_addr.push_back(path[4*i +: 4]);
            q_tag.push_back(tag);
        end
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * 4000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 / R3: reset state shows fetch word with IR write and memory read
        check("R1", upc, 4'd0, ctl, 18'b00_0_01_000_1001_1000_00);
        checks++;
        if (!(ctl[6] && ctl[9])) begin
            errors++;
            $display("FAIL R3: ir=%b rd=%b expected 1 1", ctl[6], ctl[9]);
        end
        @(posedge clk); #1;
        rst = 1'b0;

        run_instr(6'h00, 4, {4'd0, 4'd7, 4'd6, 4'd1, 4'd0}, "R6/R4/R9 rtype");
        run_instr(6'h23, 5, {4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, "R7/R9 load");
        run_instr(6'h2B, 4, {4'd0, 4'd5, 4'd2, 4'd1, 4'd0}, "R7/R3 store");
        run_instr(6'h04, 3, {4'd0, 4'd0, 4'd8, 4'd1, 4'd0}, "R6/R5 branch");
        run_instr(6'h02, 3, {4'd0, 4'd0, 4'd9, 4'd1, 4'd0}, "R5/R2 jump");
        run_instr(6'h3F, 2, {4'd0, 4'd0, 4'd0, 4'd1, 4'd0}, "R8 unmapped");
        run_instr(6'h11, 2, {4'd0, 4'd0, 4'd0, 4'd1, 4'd0}, "R8 unmapped2");
        run_instr(6'h23, 5, {4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, "R9 load again");

        // R1: reset in the middle of a routine
        opcode = 6'h00;
        q_addr.push_back(4'd0); q_tag.push_back("R1 pre");
        q_addr.push_back(4'd1); q_tag.push_back("R1 pre");
        q_addr.push_back(4'd6); q_tag.push_back("R1 pre");
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b1;
        #1;
        check("R1 async", upc, 4'd0, ctl, exp_ctl(4'd0));
        @(posedge clk); #1;
        rst = 1'b0;

        run_instr(6'h2B, 4, {4'd0, 4'd5, 4'd2, 4'd1, 4'd0}, "R2 after reset");
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule